// File: doc/BRIEF.md
# Command Buffer Pointer and Status Controller

This block is the register front end of a display command processor. Software programs a command range in external memory by writing a start pointer and an end pointer. A status register reports whether the pipe is frozen, whether a flush was requested, which busy flags are up and whether a start pointer is waiting for its end. Writes of command words to the status register set or clear control bits and zero the busy counters. Each end-pointer write emits a one-cycle `list_go` pulse to the command fetcher. It also produces a completion interrupt, which is delayed while the pipe is frozen.

Two small state machines carry the control. The range machine has the states RNG_IDLE and RNG_ARMED. A start write in RNG_IDLE stores the pointer and moves to RNG_ARMED. A start write in RNG_ARMED is dropped. An end write in RNG_ARMED copies start into current and returns to RNG_IDLE. The freeze machine has the states FRZ_RUN, FRZ_HOLD and FRZ_HOLD_DEFER. A set-freeze command moves FRZ_RUN to FRZ_HOLD. An interrupt that falls due in FRZ_HOLD moves it to FRZ_HOLD_DEFER. A clear-freeze command returns either hold state to FRZ_RUN, and leaving FRZ_HOLD_DEFER raises the interrupt that was held back. Four counters (texture memory, pipe, command buffer, clock) sit beside the two machines. Events from the pipeline increment the first three and set their busy flags. The clock counter runs while the pipe is not frozen.

Top module: `cmdbuf_ctrl`

## Requirements
- R1: After reset all pointers and counters read 0. `status_word` reads 0x0A8: bit 3 (clock started), bit 5 (pipe busy) and bit 7 (buffer ready) are set, and every other bit is 0.
- R2: A write with `wr_sel`=0 (start) stores `wr_data[23:0]` with its low 3 bits forced to 0, but only if status bit 10 (start pending) is 0. The write then sets bit 10 in either case.
- R3: A write with `wr_sel`=1 (end) always stores `wr_data[23:0]` with its low 3 bits forced to 0. If bit 10 is set, the same write copies the start pointer into `cur_ptr` and clears bit 10. Otherwise `cur_ptr` is unchanged.
- R4: Every end write produces exactly one one-cycle `list_go` pulse, in the cycle after the write edge. No other write produces one.
- R5: With `wr_sel`=2, command bit 6 clears the texture busy flag (status bit 4) and zeroes `tmem_cnt`. Bit 7 does the same for pipe busy (bit 5) and `pipe_cnt`. Bit 8 does the same for command busy (bit 6) and `cmd_cnt`. An event pulse on `tmem_evt`, `pipe_evt` or `cmd_evt` sets the matching busy flag and increments the matching counter, which saturates. A clear in the same cycle wins over the event.
- R6: Command bits act in clear/set pairs: bits 0/1 for clock started (status bit 3), bits 2/3 for freeze (status bit 1) and bits 4/5 for flush (status bit 2). A pair with both bits set leaves its status bit unchanged.
- R7: An end write while not frozen gives one one-cycle `done_irq` pulse in the next cycle. An end write while frozen gives no pulse and records a deferred interrupt. The clear-freeze command then gives exactly one pulse in the next cycle and drops the record.
- R8: `clock_cnt` increments by one every cycle while not frozen and holds while frozen. It saturates at its all-ones value, and command bit 9 zeroes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 start pointer, 1 end pointer, 2 status command |
| wr_data | input | 32 | Write data |
| tmem_evt | input | 1 | Texture memory activity event |
| pipe_evt | input | 1 | Pipe activity event |
| cmd_evt | input | 1 | Command buffer activity event |
| start_ptr | output | PTR_W | Stored start pointer |
| end_ptr | output | PTR_W | Stored end pointer |
| cur_ptr | output | PTR_W | Current pointer |
| status_word | output | 11 | Status flags |
| tmem_cnt | output | CNT_W | Texture busy counter |
| pipe_cnt | output | CNT_W | Pipe busy counter |
| cmd_cnt | output | CNT_W | Command busy counter |
| clock_cnt | output | CLK_W | Free-running clock counter |
| list_go | output | 1 | Process-list pulse to the fetcher |
| done_irq | output | 1 | Completion interrupt pulse |

## Verification
If the range machine is stuck in the wrong state, the next end write shows it. `cur_ptr` either fails to follow the start pointer or moves when it should not. A second start write either changes `start_ptr` or is dropped, when the opposite should happen. A freeze machine that loses its deferred record shows up one cycle after clear-freeze, as a missing `done_irq` pulse. One that keeps the record too long shows up as an extra pulse. A clock counter that ignores freeze differs from the held value after a few cycles, and a counter that wraps shows up at its saturation point.

// File: rtl/cmdbuf_pkg.sv
`timescale 1ns/1ps
package cmdbuf_pkg;

    localparam int STAT_W = 11;

    // status bit positions
    localparam int SB_FREEZE = 1;
    localparam int SB_FLUSH  = 2;
    localparam int SB_GCLK   = 3;
    localparam int SB_TMEM   = 4;
    localparam int SB_PIPE   = 5;
    localparam int SB_CMD    = 6;
    localparam int SB_READY  = 7;
    localparam int SB_DMA    = 8;
    localparam int SB_ENDV   = 9;
    localparam int SB_STARTV = 10;

    // status command bit positions
    localparam int CB_CLR_GCLK   = 0;
    localparam int CB_SET_GCLK   = 1;
    localparam int CB_CLR_FREEZE = 2;
    localparam int CB_SET_FREEZE = 3;
    localparam int CB_CLR_FLUSH  = 4;
    localparam int CB_SET_FLUSH  = 5;
    localparam int CB_CLR_TMEM   = 6;
    localparam int CB_CLR_PIPE   = 7;
    localparam int CB_CLR_CMD    = 8;
    localparam int CB_CLR_CLOCK  = 9;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_END   = 2'd1,
        SEL_CMD   = 2'd2
    } reg_sel_e;

    typedef enum logic {
        RNG_IDLE  = 1'b0,
        RNG_ARMED = 1'b1
    } range_st_e;

    typedef enum logic [1:0] {
        FRZ_RUN        = 2'd0,
        FRZ_HOLD       = 2'd1,
        FRZ_HOLD_DEFER = 2'd2
    } frz_st_e;

endpackage

// File: rtl/cmdbuf_range.sv
`timescale 1ns/1ps
module cmdbuf_range
    import cmdbuf_pkg::*;
#(
    parameter int PTR_W = 24,
    parameter int ALIGN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             end_wr,
    input  logic [PTR_W-1:0] wdata,
    output logic [PTR_W-1:0] start_ptr,
    output logic [PTR_W-1:0] end_ptr,
    output logic [PTR_W-1:0] cur_ptr,
    output logic             start_valid,
    output logic             list_go
);

    range_st_e        state, state_nx;
    logic [PTR_W-1:0] aligned;
    logic             unused_lo;

    assign aligned   = {wdata[PTR_W-1:ALIGN], {ALIGN{1'b0}}};
    assign unused_lo = ^wdata[ALIGN-1:0];

    always_comb begin
        state_nx = state;
        unique case (state)
            RNG_IDLE:  if (start_wr) state_nx = RNG_ARMED;
            RNG_ARMED: if (end_wr)   state_nx = RNG_IDLE;
            default:   state_nx = RNG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RNG_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_ptr <= '0;
            end_ptr   <= '0;
            cur_ptr   <= '0;
            list_go   <= 1'b0;
        end else begin
            list_go <= end_wr;
            if (start_wr && state == RNG_IDLE) start_ptr <= aligned;
            if (end_wr) begin
                end_ptr <= aligned;
                if (state == RNG_ARMED) cur_ptr <= start_ptr;
            end
        end
    end

    assign start_valid = (state == RNG_ARMED);

endmodule

// File: rtl/cmdbuf_freeze.sv
`timescale 1ns/1ps
module cmdbuf_freeze
    import cmdbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_frz,
    input  logic clr_frz,
    input  logic irq_due,
    output logic frozen,
    output logic irq
);

    frz_st_e state, state_nx;
    logic    fire;

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        unique case (state)
            FRZ_RUN: begin
                fire = irq_due;
                if (set_frz && !clr_frz) state_nx = FRZ_HOLD;
            end
            FRZ_HOLD: begin
                if (clr_frz && !set_frz) begin
                    state_nx = FRZ_RUN;
                    fire     = irq_due;
                end else if (irq_due) begin
                    state_nx = FRZ_HOLD_DEFER;
                end
            end
            FRZ_HOLD_DEFER: begin
                if (clr_frz && !set_frz) begin
                    state_nx = FRZ_RUN;
                    fire     = 1'b1;
                end
            end
            default: state_nx = FRZ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FRZ_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire;
    end

    assign frozen = (state != FRZ_RUN);

endmodule

// File: rtl/cmdbuf_busyctr.sv
`timescale 1ns/1ps
module cmdbuf_busyctr #(
    parameter int             NUM      = 3,
    parameter int             CNT_W    = 24,
    parameter logic [NUM-1:0] BUSY_RST = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM-1:0]       evt,
    input  logic [NUM-1:0]       clr,
    output logic [NUM-1:0]       busy,
    output logic [NUM*CNT_W-1:0] cnt_flat
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar i = 0; i < NUM; i++) begin : g_ctr
        logic             b_q;
        logic [CNT_W-1:0] c_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b_q <= BUSY_RST[i];
                c_q <= '0;
            end else if (clr[i]) begin
                b_q <= 1'b0;
                c_q <= '0;
            end else if (evt[i]) begin
                b_q <= 1'b1;
                if (c_q != CNT_MAX) c_q <= c_q + 1'b1;
            end
        end

        assign busy[i]                   = b_q;
        assign cnt_flat[i*CNT_W +: CNT_W] = c_q;
    end

endmodule

// File: rtl/cmdbuf_clkcnt.sv
`timescale 1ns/1ps
module cmdbuf_clkcnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt <= '0;
        else if (clr)                      cnt <= '0;
        else if (run && cnt != CNT_MAX)    cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/cmdbuf_ctrl.sv
`timescale 1ns/1ps
module cmdbuf_ctrl
    import cmdbuf_pkg::*;
#(
    parameter int PTR_W = 24,
    parameter int CNT_W = 24,
    parameter int CLK_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              tmem_evt,
    input  logic              pipe_evt,
    input  logic              cmd_evt,
    output logic [PTR_W-1:0]  start_ptr,
    output logic [PTR_W-1:0]  end_ptr,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic [10:0]       status_word,
    output logic [CNT_W-1:0]  tmem_cnt,
    output logic [CNT_W-1:0]  pipe_cnt,
    output logic [CNT_W-1:0]  cmd_cnt,
    output logic [CLK_W-1:0]  clock_cnt,
    output logic              list_go,
    output logic              done_irq
);

    localparam int NCTR = 3;

    logic            start_wr, end_wr, cmd_wr;
    logic [31:0]     cmd;
    logic            start_valid, frozen;
    logic            flush_q, gclk_q;
    logic [NCTR-1:0] ctr_evt, ctr_clr, ctr_busy;
    logic [NCTR*CNT_W-1:0] ctr_flat;
    logic            unused_hi;

    assign start_wr  = wr_en && (wr_sel == SEL_START);
    assign end_wr    = wr_en && (wr_sel == SEL_END);
    assign cmd_wr    = wr_en && (wr_sel == SEL_CMD);
    assign cmd       = cmd_wr ? wr_data : '0;
    assign unused_hi = ^wr_data[31:PTR_W];

    cmdbuf_range #(.PTR_W(PTR_W), .ALIGN(3)) u_range (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start_wr),
        .end_wr      (end_wr),
        .wdata       (wr_data[PTR_W-1:0]),
        .start_ptr   (start_ptr),
        .end_ptr     (end_ptr),
        .cur_ptr     (cur_ptr),
        .start_valid (start_valid),
        .list_go     (list_go)
    );

    cmdbuf_freeze u_freeze (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_frz (cmd[CB_SET_FREEZE]),
        .clr_frz (cmd[CB_CLR_FREEZE]),
        .irq_due (end_wr),
        .frozen  (frozen),
        .irq     (done_irq)
    );

    // order: 0 texture, 1 pipe, 2 command buffer
    assign ctr_evt = {cmd_evt, pipe_evt, tmem_evt};
    assign ctr_clr = {cmd[CB_CLR_CMD], cmd[CB_CLR_PIPE], cmd[CB_CLR_TMEM]};

    cmdbuf_busyctr #(.NUM(NCTR), .CNT_W(CNT_W), .BUSY_RST(3'b010)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (ctr_evt),
        .clr      (ctr_clr),
        .busy     (ctr_busy),
        .cnt_flat (ctr_flat)
    );

    assign tmem_cnt = ctr_flat[0*CNT_W +: CNT_W];
    assign pipe_cnt = ctr_flat[1*CNT_W +: CNT_W];
    assign cmd_cnt  = ctr_flat[2*CNT_W +: CNT_W];

    cmdbuf_clkcnt #(.W(CLK_W)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!frozen),
        .clr   (cmd[CB_CLR_CLOCK]),
        .cnt   (clock_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
            gclk_q  <= 1'b1;
        end else begin
            if (cmd[CB_SET_FLUSH] && !cmd[CB_CLR_FLUSH]) flush_q <= 1'b1;
            if (cmd[CB_CLR_FLUSH] && !cmd[CB_SET_FLUSH]) flush_q <= 1'b0;
            if (cmd[CB_SET_GCLK]  && !cmd[CB_CLR_GCLK])  gclk_q  <= 1'b1;
            if (cmd[CB_CLR_GCLK]  && !cmd[CB_SET_GCLK])  gclk_q  <= 1'b0;
        end
    end

    always_comb begin
        status_word            = '0;
        status_word[SB_FREEZE] = frozen;
        status_word[SB_FLUSH]  = flush_q;
        status_word[SB_GCLK]   = gclk_q;
        status_word[SB_TMEM]   = ctr_busy[0];
        status_word[SB_PIPE]   = ctr_busy[1];
        status_word[SB_CMD]    = ctr_busy[2];
        status_word[SB_READY]  = 1'b1;
        status_word[SB_STARTV] = start_valid;
    end

endmodule

// File: rtl/cmdbuf_ctrl_chk.sv
`timescale 1ns/1ps
module cmdbuf_ctrl_chk #(
    parameter int PTR_W = 24,
    parameter int CLK_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [31:0]      wr_data,
    input logic [PTR_W-1:0] start_ptr,
    input logic [10:0]      status_word,
    input logic [CLK_W-1:0] clock_cnt,
    input logic             list_go,
    input logic             done_irq
);

    logic w_start, w_end, w_cmd;
    assign w_start = wr_en && wr_sel == 2'd0;
    assign w_end   = wr_en && wr_sel == 2'd1;
    assign w_cmd   = wr_en && wr_sel == 2'd2;

    // R2
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_start && status_word[10]) |=> $stable(start_ptr));

    // R3
    end_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_end |=> !status_word[10]);

    // R4
    go_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_end |=> list_go);

    // R4
    go_only_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !w_end |=> !list_go);

    // R7
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[1] && !(w_cmd && wr_data[2])) |=> !done_irq);

    // R8
    clock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[1] && !(w_cmd && wr_data[9])) |=> $stable(clock_cnt));

    // R6
    flush_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !w_cmd |=> $stable(status_word[2]));

endmodule

bind cmdbuf_ctrl cmdbuf_ctrl_chk #(.PTR_W(PTR_W), .CLK_W(CLK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .start_ptr   (start_ptr),
    .status_word (status_word),
    .clock_cnt   (clock_cnt),
    .list_go     (list_go),
    .done_irq    (done_irq)
);

// File: tb/test_cmdbuf_ctrl.sv
`timescale 1ns/1ps
module test_cmdbuf_ctrl;

    localparam int PW = 24;
    localparam int CW = 24;
    localparam int KW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [31:0]   wr_data = '0;
    logic          tmem_evt = 1'b0, pipe_evt = 1'b0, cmd_evt = 1'b0;
    logic [PW-1:0] start_ptr, end_ptr, cur_ptr;
    logic [10:0]   status_word;
    logic [CW-1:0] tmem_cnt, pipe_cnt, cmd_cnt;
    logic [KW-1:0] clock_cnt;
    logic          list_go, done_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int go_q[$];
    int irq_q[$];
    bit m_frz = 0, m_def = 0;
    bit fin = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmdbuf_ctrl #(.PTR_W(PW), .CNT_W(CW), .CLK_W(KW)) i_cmdbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tmem_evt(tmem_evt), .pipe_evt(pipe_evt), .cmd_evt(cmd_evt),
        .start_ptr(start_ptr), .end_ptr(end_ptr), .cur_ptr(cur_ptr),
        .status_word(status_word), .tmem_cnt(tmem_cnt), .pipe_cnt(pipe_cnt),
        .cmd_cnt(cmd_cnt), .clock_cnt(clock_cnt), .list_go(list_go), .done_irq(done_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // monitor: pops expected pulse cycles as pulses appear
    always @(negedge clk) if (rst_n && !fin) begin
        if (list_go) begin
            checks++;
            if (go_q.size() > 0 && go_q[0] == cyc) void'(go_q.pop_front());
            else begin errors++; $display("FAIL R4: got list_go at %0d expected none", cyc); end
        end else if (go_q.size() > 0 && go_q[0] <= cyc) begin
            checks++; errors++;
            $display("FAIL R4: got no list_go at %0d expected pulse", cyc);
            void'(go_q.pop_front());
        end
        if (done_irq) begin
            checks++;
            if (irq_q.size() > 0 && irq_q[0] == cyc) void'(irq_q.pop_front());
            else begin errors++; $display("FAIL R7: got done_irq at %0d expected none", cyc); end
        end else if (irq_q.size() > 0 && irq_q[0] <= cyc) begin
            checks++; errors++;
            $display("FAIL R7: got no done_irq at %0d expected pulse", cyc);
            void'(irq_q.pop_front());
        end
    end

    // driver: one register write, pushing the pulses it should cause
    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        if (sel == 2'd1) begin
            go_q.push_back(cyc + 1);
            if (!m_frz) irq_q.push_back(cyc + 1);
            else m_def = 1;
        end
        if (sel == 2'd2) begin
            if (d[2] && !d[3]) begin
                if (m_def) irq_q.push_back(cyc + 1);
                m_frz = 0; m_def = 0;
            end
            if (d[3] && !d[2]) m_frz = 1;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        tmem_evt = (which == 0); pipe_evt = (which == 1); cmd_evt = (which == 2);
        @(negedge clk);
        tmem_evt = 0; pipe_evt = 0; cmd_evt = 0;
    endtask

    initial begin
        #(2_000_000);
        if (!fin) begin
            fin = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [KW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 status", 32'(status_word), 32'h0A8);
        chk("R1 start", 32'(start_ptr), 0);
        chk("R1 cur", 32'(cur_ptr), 0);
        chk("R1 pipe_cnt", 32'(pipe_cnt), 0);

        // R2 start write aligns and arms
        wr(2'd0, 32'h0012_3457);
        chk("R2 start", 32'(start_ptr), 32'h12_3450);
        chk("R2 pending", 32'(status_word[10]), 1);
        // R2 second start dropped
        wr(2'd0, 32'h0077_7777);
        chk("R2 ignored", 32'(start_ptr), 32'h12_3450);
        chk("R2 pending kept", 32'(status_word[10]), 1);

        // R3 end write copies start
        wr(2'd1, 32'h00AB_CDEF);
        chk("R3 end", 32'(end_ptr), 32'hAB_CDE8);
        chk("R3 cur", 32'(cur_ptr), 32'h12_3450);
        chk("R3 pending cleared", 32'(status_word[10]), 0);
        // R3 end without pending start
        wr(2'd1, 32'h0000_1234);
        chk("R3 end2", 32'(end_ptr), 32'h00_1230);
        chk("R3 cur kept", 32'(cur_ptr), 32'h12_3450);
        // new range
        wr(2'd0, 32'h0000_4440);
        chk("R2 rearm", 32'(start_ptr), 32'h00_4440);
        wr(2'd1, 32'h0000_5000);
        chk("R3 cur new", 32'(cur_ptr), 32'h00_4440);

        // R5 counters
        pulse(0); pulse(0);
        chk("R5 tmem_cnt", 32'(tmem_cnt), 2);
        chk("R5 tmem busy", 32'(status_word[4]), 1);
        wr(2'd2, 32'h040);
        chk("R5 tmem clr cnt", 32'(tmem_cnt), 0);
        chk("R5 tmem clr busy", 32'(status_word[4]), 0);
        pulse(1);
        chk("R5 pipe_cnt", 32'(pipe_cnt), 1);
        wr(2'd2, 32'h080);
        chk("R5 pipe clr", 32'({status_word[5], pipe_cnt}), 0);
        pulse(2); pulse(2); pulse(2);
        chk("R5 cmd_cnt", 32'(cmd_cnt), 3);
        chk("R5 cmd busy", 32'(status_word[6]), 1);
        wr(2'd2, 32'h100);
        chk("R5 cmd clr", 32'({status_word[6], cmd_cnt}), 0);

        // R6 pairs
        wr(2'd2, 32'h020);
        chk("R6 flush set", 32'(status_word[2]), 1);
        wr(2'd2, 32'h030);
        chk("R6 flush both", 32'(status_word[2]), 1);
        wr(2'd2, 32'h010);
        chk("R6 flush clr", 32'(status_word[2]), 0);
        wr(2'd2, 32'h001);
        chk("R6 gclk clr", 32'(status_word[3]), 0);
        wr(2'd2, 32'h002);
        chk("R6 gclk set", 32'(status_word[3]), 1);
        wr(2'd2, 32'h00C);
        chk("R6 freeze both", 32'(status_word[1]), 0);

        // R8 clock runs
        wr(2'd2, 32'h200);
        chk("R8 clock clr", 32'(clock_cnt), 0);
        repeat (3) @(negedge clk);
        chk("R8 clock run", 32'(clock_cnt), 3);

        // R6/R8 freeze
        wr(2'd2, 32'h008);
        chk("R6 freeze set", 32'(status_word[1]), 1);
        held = clock_cnt;
        repeat (5) @(negedge clk);
        chk("R8 clock held", 32'(clock_cnt), 32'(held));

        // R7 deferred interrupt
        wr(2'd1, 32'h0000_6000);
        repeat (4) @(negedge clk);
        chk("R7 no irq while frozen", 32'(irq_q.size()), 0);
        wr(2'd2, 32'h004);
        chk("R6 freeze clr", 32'(status_word[1]), 0);
        @(negedge clk);
        chk("R7 deferred raised", 32'(irq_q.size()), 0);
        // R7 unfreeze with nothing deferred: no pulse
        wr(2'd2, 32'h008);
        wr(2'd2, 32'h004);

        // R8 saturation
        wr(2'd2, 32'h200);
        repeat (300) @(negedge clk);
        chk("R8 saturate", 32'(clock_cnt), 32'hFF);

        repeat (3) @(negedge clk);
        chk("R4 queue drained", 32'(go_q.size()), 0);
        chk("R7 queue drained", 32'(irq_q.size()), 0);
        fin = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule